// File: doc/BRIEF.md
# Graphics Palette Translator and Video Blender

This block turns a stream of graphics pixel codes into colour and transparency, then mixes that colour over a live video pixel stream. A code may be 2, 4 or 8 bits wide. Low-depth codes can first go through a small reduction table, so that a 2- or 4-bit code can pick any entry of a larger palette. The resulting index reads a 256-entry palette. Each palette entry holds 8-bit luma, two 8-bit chroma values and a 6-bit transparency.

The transparency weights the graphics colour against the video colour. There are 64 levels, from pure video to fully opaque graphics. Each graphics pixel carries a translation mode chosen by whatever manages the current box. A host write port loads the palette and the three reduction tables.

A palette write is applied only while the blanking input is high. A write that arrives during active video is held back and applied at the next blanking interval. Reduction table writes take effect at once.

Top module: `gfxClutMixer`

## Requirements
- R1: After reset `outValid` is 0 and `outY`, `outU` and `outV` are 0.
- R2: A pixel accepted with `pixValid` high at a clock edge appears on the outputs with `outValid` high exactly three edges later. `outValid` is high only for such pixels.
- R3: For an 8-bit pixel the full code indexes the palette directly in every mode. `pixDepth` uses 0 for 2 bits per pixel, 1 for 4 bits, and 2 or 3 for 8 bits.
- R4: In `mapMode` 0 or 3, a 2- or 4-bit pixel uses its low 2 or 4 code bits, zero-extended, as the palette index. Code bits above the depth are ignored.
- R5: In `mapMode` 1, a 2-bit code indexes a 4-entry table of 8-bit palette indices, and a 4-bit code indexes a 16-entry table of 8-bit palette indices.
- R6: In `mapMode` 2, a 2-bit code indexes a 4-entry table of 4-bit values, which are zero-extended to the palette index. A 4-bit code is used directly.
- R7: Each output component equals (T·G + (63−T)·V + 31)/63, truncated, where G is the palette component, V is the video component and T is the palette transparency. T=63 gives G and T=0 gives V.
- R8: A palette write has `hostSel`=0 and `hostData` laid out as Y[29:22], U[21:14], V[13:6], T[5:0]. It is applied at the next edge if `blanking` is high. Otherwise it is held and applied on the first edge at which `blanking` is high, and pixels before that still see the old entry.
- R9: While a palette write is held, a later palette write during active video replaces it, and the earlier data is never applied.
- R10: A table write with `hostSel` 1 (4×8-bit table), 2 (16×8-bit table) or 3 (4×4-bit table) takes `hostAddr` and `hostData[7:0]` (or `[3:0]` for the 4-bit table). It applies at the next edge whatever the state of `blanking`.
- R11: While `outValid` is low, `outY`, `outU` and `outV` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Graphics pixel present |
| pixCode | input | 8 | Graphics pixel code |
| pixDepth | input | 2 | Code depth: 0=2 bit, 1=4 bit, 2/3=8 bit |
| mapMode | input | 2 | Translation mode: 0/3 direct, 1 wide tables, 2 narrow table |
| vidY | input | 8 | Video luma, aligned with the pixel |
| vidU | input | 8 | Video U chroma |
| vidV | input | 8 | Video V chroma |
| blanking | input | 1 | High during the interval between graphics lines |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostSel | input | 2 | Write target: 0 palette, 1/2/3 reduction tables |
| hostAddr | input | 8 | Entry address |
| hostData | input | 30 | Write data |
| outValid | output | 1 | Blended pixel present |
| outY | output | 8 | Blended luma |
| outU | output | 8 | Blended U |
| outV | output | 8 | Blended V |

## Verification
The palette is filled so that each entry's components and transparency differ from its neighbours'. A wrong index therefore shows up in the output. Each depth is driven in every translation mode, with code bits set above the depth, so that direct indexing, wide-table translation and narrow-table translation each give a distinct result. Entries with transparency 0, 63 and values in between separate pure video, pure graphics and rounding errors. Palette writes made during active video are checked by reading the entry before and after blanking, including a second write that must replace the first. A table write during active video is followed at once by a pixel that uses it.

// File: rtl/gfxMixPkg.sv
package gfxMixPkg;
  localparam int COMP_W   = 8;
  localparam int T_W      = 6;
  localparam int IDX_W    = 8;
  localparam int CODE_W   = 8;
  localparam int NARROW_W = 4;
  localparam int WIDE2_N  = 4;
  localparam int WIDE4_N  = 16;
  localparam int NARROW_N = 4;
  localparam int MAP_AW   = 4;
  localparam int CLUT_N   = 1 << IDX_W;
  localparam int TMAX     = (1 << T_W) - 1;
  localparam int HOST_W   = 3 * COMP_W + T_W;
  localparam int ACC_W    = COMP_W + T_W + 1;

  typedef struct packed {
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] u;
    logic [COMP_W-1:0] v;
    logic [T_W-1:0]    t;
  } clutEntry_t;

  typedef enum logic [1:0] {
    SEL_CLUT   = 2'd0,
    SEL_WIDE2  = 2'd1,
    SEL_WIDE4  = 2'd2,
    SEL_NARROW = 2'd3
  } hostSel_e;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_WIDE    = 2'd1,
    MODE_NARROW  = 2'd2,
    MODE_DIRECT2 = 2'd3
  } mapMode_e;

  localparam logic [1:0] DEPTH_2 = 2'd0;
  localparam logic [1:0] DEPTH_4 = 2'd1;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic              clutWe;
    logic [IDX_W-1:0]  clutAddr;
    clutEntry_t        clutData;
    logic [2:0]        mapWe;     // [0] wide2, [1] wide4, [2] narrow
    logic [MAP_AW-1:0] mapAddr;
    logic [COMP_W-1:0] mapData;
  } wrStrobe_t;

  function automatic logic [COMP_W-1:0] blendComp(
    input logic [COMP_W-1:0] g,
    input logic [COMP_W-1:0] v,
    input logic [T_W-1:0]    t
  );
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(t) * ACC_W'(g)
        + (ACC_W'(TMAX) - ACC_W'(t)) * ACC_W'(v)
        + ACC_W'(TMAX / 2);
    return COMP_W'(acc / ACC_W'(TMAX));
  endfunction
endpackage

// File: rtl/gfxMixCtrl.sv
module gfxMixCtrl
  import gfxMixPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               blanking,
  input  logic               hostWrEn,
  input  logic [1:0]         hostSel,
  input  logic [IDX_W-1:0]   hostAddr,
  input  logic [HOST_W-1:0]  hostData,
  output wrStrobe_t          wrStb
);
  logic             pendValid;
  logic [IDX_W-1:0] pendAddr;
  clutEntry_t       pendData;
  logic             clutReq;
  hostSel_e         selE;

  assign selE    = hostSel_e'(hostSel);
  assign clutReq = hostWrEn && (selE == SEL_CLUT);

  always_comb begin
    wrStb          = '0;
    wrStb.mapAddr  = hostAddr[MAP_AW-1:0];
    wrStb.mapData  = hostData[COMP_W-1:0];
    wrStb.mapWe[0] = hostWrEn && (selE == SEL_WIDE2);
    wrStb.mapWe[1] = hostWrEn && (selE == SEL_WIDE4);
    wrStb.mapWe[2] = hostWrEn && (selE == SEL_NARROW);
    if (blanking) begin
      if (pendValid) begin
        wrStb.clutWe   = 1'b1;
        wrStb.clutAddr = pendAddr;
        wrStb.clutData = pendData;
      end else if (clutReq) begin
        wrStb.clutWe   = 1'b1;
        wrStb.clutAddr = hostAddr;
        wrStb.clutData = clutEntry_t'(hostData);
      end
    end
  end

  // Single hold slot: a newer write overwrites it; during blanking a
  // write that collides with a flush takes the slot for the next cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (clutReq && (!blanking || pendValid)) begin
      pendValid <= 1'b1;
      pendAddr  <= hostAddr;
      pendData  <= clutEntry_t'(hostData);
    end else if (blanking) begin
      pendValid <= 1'b0;
    end
  end
endmodule

// File: rtl/gfxMixPath.sv
module gfxMixPath
  import gfxMixPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  logic              pixValid,
  input  logic [CODE_W-1:0] pixCode,
  input  logic [1:0]        pixDepth,
  input  logic [1:0]        mapMode,
  input  logic [COMP_W-1:0] vidY,
  input  logic [COMP_W-1:0] vidU,
  input  logic [COMP_W-1:0] vidV,
  output logic              outValid,
  output logic [COMP_W-1:0] outY,
  output logic [COMP_W-1:0] outU,
  output logic [COMP_W-1:0] outV
);
  localparam int W2_AW = $clog2(WIDE2_N);
  localparam int W4_AW = $clog2(WIDE4_N);
  localparam int NR_AW = $clog2(NARROW_N);

  clutEntry_t          clutMem   [CLUT_N];
  logic [IDX_W-1:0]    wide2Tab  [WIDE2_N];
  logic [IDX_W-1:0]    wide4Tab  [WIDE4_N];
  logic [NARROW_W-1:0] narrowTab [NARROW_N];

  always_ff @(posedge clk) begin
    if (wrStb.clutWe) clutMem[wrStb.clutAddr] <= wrStb.clutData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WIDE2_N; i++)  wide2Tab[i]  <= '0;
      for (int i = 0; i < WIDE4_N; i++)  wide4Tab[i]  <= '0;
      for (int i = 0; i < NARROW_N; i++) narrowTab[i] <= '0;
    end else begin
      if (wrStb.mapWe[0]) wide2Tab[wrStb.mapAddr[W2_AW-1:0]]  <= wrStb.mapData[IDX_W-1:0];
      if (wrStb.mapWe[1]) wide4Tab[wrStb.mapAddr[W4_AW-1:0]]  <= wrStb.mapData[IDX_W-1:0];
      if (wrStb.mapWe[2]) narrowTab[wrStb.mapAddr[NR_AW-1:0]] <= wrStb.mapData[NARROW_W-1:0];
    end
  end

  // Stage 1: code -> palette index
  logic [IDX_W-1:0] idxNext;
  logic [W2_AW-1:0] code2;
  logic [W4_AW-1:0] code4;
  mapMode_e         modeE;

  assign code2 = pixCode[W2_AW-1:0];
  assign code4 = pixCode[W4_AW-1:0];
  assign modeE = mapMode_e'(mapMode);

  always_comb begin
    idxNext = pixCode[IDX_W-1:0];
    if (pixDepth == DEPTH_2) begin
      unique case (modeE)
        MODE_WIDE:   idxNext = wide2Tab[code2];
        MODE_NARROW: idxNext = IDX_W'(narrowTab[code2[NR_AW-1:0]]);
        default:     idxNext = IDX_W'(code2);
      endcase
    end else if (pixDepth == DEPTH_4) begin
      if (modeE == MODE_WIDE) idxNext = wide4Tab[code4];
      else                    idxNext = IDX_W'(code4);
    end
  end

  logic              s1Valid, s2Valid;
  logic [IDX_W-1:0]  s1Idx;
  logic [COMP_W-1:0] s1Y, s1U, s1V, s2Y, s2U, s2V;
  clutEntry_t        s2Ent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0; s1Idx <= '0; s1Y <= '0; s1U <= '0; s1V <= '0;
      s2Valid <= 1'b0; s2Ent <= '0; s2Y <= '0; s2U <= '0; s2V <= '0;
      outValid <= 1'b0; outY <= '0; outU <= '0; outV <= '0;
    end else begin
      s1Valid <= pixValid;
      s1Idx   <= idxNext;
      s1Y     <= vidY; s1U <= vidU; s1V <= vidV;
      // Stage 2: palette read
      s2Valid <= s1Valid;
      s2Ent   <= clutMem[s1Idx];
      s2Y     <= s1Y; s2U <= s1U; s2V <= s1V;
      // Stage 3: blend
      outValid <= s2Valid;
      outY <= s2Valid ? blendComp(s2Ent.y, s2Y, s2Ent.t) : '0;
      outU <= s2Valid ? blendComp(s2Ent.u, s2U, s2Ent.t) : '0;
      outV <= s2Valid ? blendComp(s2Ent.v, s2V, s2Ent.t) : '0;
    end
  end
endmodule

// File: rtl/gfxClutMixer.sv
module gfxClutMixer
  import gfxMixPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [CODE_W-1:0] pixCode,
  input  logic [1:0]        pixDepth,
  input  logic [1:0]        mapMode,
  input  logic [COMP_W-1:0] vidY,
  input  logic [COMP_W-1:0] vidU,
  input  logic [COMP_W-1:0] vidV,
  input  logic              blanking,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [IDX_W-1:0]  hostAddr,
  input  logic [HOST_W-1:0] hostData,
  output logic              outValid,
  output logic [COMP_W-1:0] outY,
  output logic [COMP_W-1:0] outU,
  output logic [COMP_W-1:0] outV
);
  wrStrobe_t wrStb;

  gfxMixCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .blanking(blanking), .hostWrEn(hostWrEn),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostData(hostData), .wrStb(wrStb)
  );

  gfxMixPath u_path (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .pixValid(pixValid),
    .pixCode(pixCode), .pixDepth(pixDepth), .mapMode(mapMode),
    .vidY(vidY), .vidU(vidU), .vidV(vidV), .outValid(outValid),
    .outY(outY), .outU(outU), .outV(outV)
  );
endmodule

// File: rtl/gfxClutMixerChecker.sv
module gfxClutMixerChecker
  import gfxMixPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pixValid,
  input logic              outValid,
  input logic [COMP_W-1:0] outY,
  input logic [COMP_W-1:0] outU,
  input logic [COMP_W-1:0] outV,
  input logic              blanking,
  input logic              hostWrEn,
  input logic [1:0]        hostSel,
  input logic              clutWe,
  input logic [2:0]        mapWe
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(pixValid, 3));

  p_clut_in_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
    clutWe |-> blanking);

  p_held_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostWrEn && hostSel == 2'd0 && !blanking) && blanking) |-> clutWe);

  p_map_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mapWe));

  p_map_direct_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostSel != 2'd0) |-> $countones(mapWe) == 1);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outY == '0 && outU == '0 && outV == '0));
endmodule

bind gfxClutMixer gfxClutMixerChecker u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .outValid(outValid),
  .outY(outY), .outU(outU), .outV(outV), .blanking(blanking),
  .hostWrEn(hostWrEn), .hostSel(hostSel), .clutWe(wrStb.clutWe),
  .mapWe(wrStb.mapWe)
);

// File: tb/gfxClutMixer_bench.sv
module gfxClutMixer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [7:0] pixCode = '0;
  logic [1:0] pixDepth = '0;
  logic [1:0] mapMode = '0;
  logic [7:0] vidY = '0, vidU = '0, vidV = '0;
  logic blanking = 1'b1;
  logic hostWrEn = 1'b0;
  logic [1:0] hostSel = '0;
  logic [7:0] hostAddr = '0;
  logic [29:0] hostData = '0;
  logic outValid;
  logic [7:0] outY, outU, outV;

  gfxClutMixer u_gfxClutMixer (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixCode(pixCode),
    .pixDepth(pixDepth), .mapMode(mapMode), .vidY(vidY), .vidU(vidU),
    .vidV(vidV), .blanking(blanking), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostAddr(hostAddr), .hostData(hostData), .outValid(outValid),
    .outY(outY), .outU(outU), .outV(outV)
  );

  always #10 clk = ~clk;

  typedef struct {
    int unsigned due;
    logic [7:0] y, u, v;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;
  bit done = 0;
  bit monOn = 0;

  logic [29:0] modelClut [256];
  logic [7:0]  modelW2 [4];
  logic [7:0]  modelW4 [16];
  logic [3:0]  modelNr [4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mix(input logic [7:0] g, input logic [7:0] v, input logic [5:0] t);
    int acc;
    acc = int'(t) * int'(g) + (63 - int'(t)) * int'(v) + 31;
    return 8'(acc / 63);
  endfunction

  function automatic logic [7:0] expIdx(input logic [7:0] code, input logic [1:0] depth, input logic [1:0] mode);
    if (depth == 2'd0) begin
      if (mode == 2'd1) return modelW2[code[1:0]];
      if (mode == 2'd2) return {4'd0, modelNr[code[1:0]]};
      return {6'd0, code[1:0]};
    end
    if (depth == 2'd1) begin
      if (mode == 2'd1) return modelW4[code[3:0]];
      return {4'd0, code[3:0]};
    end
    return code;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] addr, input logic [29:0] data);
    hostWrEn = 1'b1; hostSel = sel; hostAddr = addr; hostData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic sendPix(input string req, input logic [7:0] code, input logic [1:0] depth,
                         input logic [1:0] mode, input logic [7:0] vy, input logic [7:0] vu,
                         input logic [7:0] vv);
    expItem_t it;
    logic [29:0] e;
    e = modelClut[expIdx(code, depth, mode)];
    it.due = cyc + 3;
    it.y = mix(e[29:22], vy, e[5:0]);
    it.u = mix(e[21:14], vu, e[5:0]);
    it.v = mix(e[13:6], vv, e[5:0]);
    it.req = req;
    expQ.push_back(it);
    pixValid = 1'b1; pixCode = code; pixDepth = depth; mapMode = mode;
    vidY = vy; vidU = vu; vidV = vv;
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  // Monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected output", 32'd1, 32'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check({"R2 latency ", it.req}, cyc, it.due);
          check({it.req, " Y"}, {24'd0, outY}, {24'd0, it.y});
          check({it.req, " U"}, {24'd0, outU}, {24'd0, it.u});
          check({it.req, " V"}, {24'd0, outV}, {24'd0, it.v});
        end
      end else begin
        if (expQ.size() != 0 && expQ[0].due <= cyc)
          check("R2 missing output", 32'd0, 32'd1);
        check("R11 idle outputs zero", {8'd0, outY, outU, outV}, 32'd0);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  function automatic logic [29:0] palette(input int i);
    return {8'(i), 8'(255 - i), 8'((i * 7) & 255), 6'(i & 63)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    check("R1 outputs", {8'd0, outY, outU, outV}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // Load palette during blanking (R8 direct path)
    for (int i = 0; i < 256; i++) begin
      modelClut[i] = palette(i);
      hostWrite(2'd0, 8'(i), palette(i));
    end
    modelW2 = '{8'd200, 8'd17, 8'd99, 8'd250};
    modelNr = '{4'd3, 4'd9, 4'd12, 4'd15};
    for (int i = 0; i < 4; i++) hostWrite(2'd1, 8'(i), {22'd0, modelW2[i]});
    for (int i = 0; i < 16; i++) begin
      modelW4[i] = 8'((i * 13 + 5) & 255);
      hostWrite(2'd2, 8'(i), {22'd0, modelW4[i]});
    end
    for (int i = 0; i < 4; i++) hostWrite(2'd3, 8'(i), {26'h3ff_fff0, modelNr[i]});
    blanking = 1'b0;
    @(negedge clk);

    // R3: 8-bit codes, all modes, depth 2 and 3, back to back
    for (int i = 0; i < 24; i++)
      sendPix("R3 8bpp", 8'((i * 37 + 3) & 255), 2'(2 + (i & 1)), 2'(i & 3),
              8'(i * 11), 8'(250 - i * 5), 8'(i * 3 + 40));
    // R4: direct mode, upper code bits set
    for (int i = 0; i < 16; i++)
      sendPix("R4 direct", 8'(8'hA0 | i), 2'(i & 1), (i < 8) ? 2'd0 : 2'd3,
              8'(i * 15), 8'(i * 9), 8'(255 - i));
    // R5: wide tables, with gaps
    for (int i = 0; i < 16; i++) begin
      sendPix("R5 wide", 8'(8'hF0 | i), 2'(i & 1), 2'd1, 8'(i * 7), 8'(100 + i), 8'(60));
      if (i % 3 == 0) @(negedge clk);
    end
    // R6: narrow table
    for (int i = 0; i < 8; i++)
      sendPix("R6 narrow", 8'(8'hC0 | (i * 5)), 2'(i & 1), 2'd2, 8'(30 * i), 8'(20), 8'(200 - i));
    // R7: blend corners (entry 63: T=63, entry 64: T=0, entry 32: T=32)
    sendPix("R7 opaque", 8'd63, 2'd2, 2'd0, 8'd10, 8'd20, 8'd30);
    sendPix("R7 transparent", 8'd64, 2'd2, 2'd0, 8'd201, 8'd7, 8'd99);
    sendPix("R7 half", 8'd32, 2'd2, 2'd0, 8'd255, 8'd0, 8'd128);
    repeat (5) @(negedge clk);

    // R8/R9: held palette write during active video
    hostWrite(2'd0, 8'd5, {8'd1, 8'd2, 8'd3, 6'd63});
    sendPix("R8 held old", 8'd5, 2'd2, 2'd0, 8'd50, 8'd60, 8'd70);
    hostWrite(2'd0, 8'd5, {8'd240, 8'd120, 8'd60, 6'd63});
    repeat (4) @(negedge clk);
    sendPix("R9 still old", 8'd5, 2'd2, 2'd0, 8'd50, 8'd60, 8'd70);
    repeat (4) @(negedge clk);
    blanking = 1'b1;
    modelClut[5] = {8'd240, 8'd120, 8'd60, 6'd63};
    repeat (2) @(negedge clk);
    blanking = 1'b0;
    sendPix("R9 replaced value", 8'd5, 2'd2, 2'd0, 8'd50, 8'd60, 8'd70);

    // R10: table write during active video used on the next cycle
    modelW2[1] = 8'd77;
    hostWrite(2'd1, 8'd1, 30'd77);
    sendPix("R10 wide2 immediate", 8'd1, 2'd0, 2'd1, 8'd9, 8'd8, 8'd7);
    modelNr[2] = 4'd6;
    hostWrite(2'd3, 8'd2, 30'd6);
    sendPix("R10 narrow immediate", 8'd2, 2'd0, 2'd2, 8'd90, 8'd80, 8'd70);

    repeat (8) @(negedge clk);
    check("R2 queue drained", expQ.size(), 32'd0);
    done = 1'b1;
    finishRun();
  end
endmodule